// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Unit

This block is the addressing layer of a slave on a single-wire, open-drain, multidrop bus. The slot layer below it turns bus timing into three clock-synchronous events: a bus-reset strobe, received-bit strobes with their value, and read-slot requests. The unit answers a read-slot request in the same cycle with a pull-low decision. It holds a 64-bit identity made of an 8-bit device class code, a 48-bit serial value and an 8-bit check byte. The check byte is computed when the design elaborates. After a bus reset the unit receives one command byte and then runs one of four addressing operations: identity readout, identity compare, tree search or broadcast bypass.

When an operation succeeds, the unit raises `selected` toward the memory-function layer. It holds that flag until the next bus reset. After a compare failure, a search drop-out or an unknown command, the unit stays silent until the next bus reset.

Top module: `owSlaveRom`

## Requirements
- R1: After `rstN` falls, and until the first `busReset`, all strobes are ignored and `selected` stays 0. `presence` is high for exactly the cycle after each `busReset`.
- R2: The command byte is taken least significant bit first, one bit per `rxValid`. The codes are 0x33 (readout), 0x55 (compare), 0xF0 (search) and 0xCC (bypass).
- R3: The identity holds the class code in bits 7:0, the serial value in bits 55:8, and in bits 63:56 the check byte. The check byte is the reflected CRC-8 (polynomial x^8+x^5+x^4+1, initial value 0) over bits 55:0, fed LSB first. Readout sends bits 0 to 63 in that order, one per `txReq`.
- R4: `selected` rises after the 64th readout slot and not before.
- R5: Compare takes 64 bits on `rxValid`. `selected` rises after the 64th bit if every bit equalled the identity.
- R6: On the first compare bit that differs from the identity, the unit goes idle. It never selects and never pulls low until the next `busReset`.
- R7: Search runs three slots per identity bit, from bit 0 upward. The first `txReq` sends the true bit and the second sends its complement. The following `rxValid` takes the bit the master chose.
- R8: If the chosen bit differs from its own bit, the unit leaves the search and releases the line on all further slots until a `busReset`.
- R9: After 64 search triplets that all agree, `selected` rises.
- R10: Bypass raises `selected` right after the 8th command bit. `selected` then holds until a `busReset`.
- R11: `pullLow` is 1 only during a `txReq` cycle in which the unit sends a 0. Sending a 1 leaves the line released.
- R12: An unknown command code makes the unit idle. It does not select and does not pull low until the next `busReset`.
- R13: A `busReset` at any point clears `selected` and aborts the current operation. The next command starts with a fresh bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | Strobe: bus reset pulse detected |
| rxValid | input | 1 | Strobe: a bit was written by the master |
| rxBit | input | 1 | Value of the written bit |
| txReq | input | 1 | Strobe: master opened a read slot |
| pullLow | output | 1 | Drive the line low during this read slot |
| presence | output | 1 | One-cycle presence request after a bus reset |
| selected | output | 1 | Device addressed; memory layer may proceed |

## Verification
The bench aims at the boundary bits of each operation. A bit counter that is off by one would raise `selected` one slot early or late in readout, compare or search. A wrong bit order or polarity would show up as a wrong pull-low pattern in readout and in the search complement slot. A unit that keeps listening after a compare mismatch, a search drop-out or a bad command would drive the line later or select itself. A bus reset in the middle of a readout must restart the identity at bit 0; a design that kept its count would send the wrong bits. Strobes sent before the first bus reset must not select the device.

// File: rtl/owRomPkg.sv
package owRomPkg;
  localparam int ROM_BITS = 64;
  localparam int CMD_BITS = 8;
  localparam int IDX_W = $clog2(ROM_BITS);

  localparam logic [CMD_BITS-1:0] CMD_READ   = 8'h33;
  localparam logic [CMD_BITS-1:0] CMD_MATCH  = 8'h55;
  localparam logic [CMD_BITS-1:0] CMD_SEARCH = 8'hF0;
  localparam logic [CMD_BITS-1:0] CMD_SKIP   = 8'hCC;

  typedef enum logic [2:0] {
    ST_DEAD, ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_DONE
  } romState_t;

  typedef struct packed {
    logic clrIdx;
    logic stepIdx;
    logic clrPhase;
    logic stepPhase;
    logic shiftCmd;
  } romStrobes_t;

  // Reflected CRC-8, polynomial x^8+x^5+x^4+1, bits taken LSB first.
  function automatic logic [7:0] idCrc(input logic [55:0] data);
    logic [7:0] acc;
    logic fb;
    acc = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = acc[0] ^ data[i];
      acc = acc >> 1;
      if (fb) acc = acc ^ 8'h8C;
    end
    return acc;
  endfunction
endpackage

// File: rtl/owRomDatapath.sv
module owRomDatapath
  import owRomPkg::*;
#(
  parameter logic [7:0]  CLASS_CODE = 8'h2D,
  parameter logic [47:0] SERIAL_VAL = 48'h0000_5A3C_91E7
) (
  input  logic               clk,
  input  logic               rstN,
  input  romStrobes_t        strobes,
  input  logic               rxBit,
  output logic [CMD_BITS-1:0] cmdNext,
  output logic               lastCmdBit,
  output logic               lastRomBit,
  output logic               romBit,
  output logic [1:0]         phase
);
  localparam logic [55:0] ID_LOW = {SERIAL_VAL, CLASS_CODE};
  localparam logic [ROM_BITS-1:0] ID_FULL = {idCrc(ID_LOW), ID_LOW};

  logic [CMD_BITS-1:0] cmdShift;
  logic [IDX_W-1:0]    bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdShift <= '0;
      bitIdx   <= '0;
      phase    <= '0;
    end else begin
      if (strobes.shiftCmd) cmdShift <= cmdNext;
      if (strobes.clrIdx)       bitIdx <= '0;
      else if (strobes.stepIdx) bitIdx <= bitIdx + 1'b1;
      if (strobes.clrPhase)       phase <= '0;
      else if (strobes.stepPhase) phase <= phase + 1'b1;
    end
  end

  assign cmdNext    = {rxBit, cmdShift[CMD_BITS-1:1]};
  assign lastCmdBit = (bitIdx == IDX_W'(CMD_BITS - 1));
  assign lastRomBit = (bitIdx == IDX_W'(ROM_BITS - 1));
  assign romBit     = ID_FULL[bitIdx];
endmodule

// File: rtl/owRomControl.sv
module owRomControl
  import owRomPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReset,
  input  logic               rxValid,
  input  logic               rxBit,
  input  logic               txReq,
  input  logic [CMD_BITS-1:0] cmdNext,
  input  logic               lastCmdBit,
  input  logic               lastRomBit,
  input  logic               romBit,
  input  logic [1:0]         phase,
  output romStrobes_t        strobes,
  output logic               pullLow,
  output logic               presence,
  output logic               selected
);
  romState_t state, nextState;
  logic setSel;

  always_comb begin
    strobes   = '0;
    nextState = state;
    setSel    = 1'b0;
    pullLow   = 1'b0;
    if (busReset) begin
      nextState        = ST_CMD;
      strobes.clrIdx   = 1'b1;
      strobes.clrPhase = 1'b1;
    end else begin
      case (state)
        ST_CMD: if (rxValid) begin
          strobes.shiftCmd = 1'b1;
          if (lastCmdBit) begin
            strobes.clrIdx = 1'b1;
            case (cmdNext)
              CMD_READ:   nextState = ST_READ;
              CMD_MATCH:  nextState = ST_MATCH;
              CMD_SEARCH: nextState = ST_SEARCH;
              CMD_SKIP: begin
                nextState = ST_DONE;
                setSel    = 1'b1;
              end
              default:    nextState = ST_DEAD;
            endcase
          end else begin
            strobes.stepIdx = 1'b1;
          end
        end
        ST_READ: if (txReq) begin
          pullLow         = !romBit;
          strobes.stepIdx = 1'b1;
          if (lastRomBit) begin
            nextState = ST_DONE;
            setSel    = 1'b1;
          end
        end
        ST_MATCH: if (rxValid) begin
          if (rxBit != romBit) begin
            nextState = ST_DEAD;
          end else begin
            strobes.stepIdx = 1'b1;
            if (lastRomBit) begin
              nextState = ST_DONE;
              setSel    = 1'b1;
            end
          end
        end
        ST_SEARCH: begin
          if (phase == 2'd0 && txReq) begin
            pullLow           = !romBit;
            strobes.stepPhase = 1'b1;
          end else if (phase == 2'd1 && txReq) begin
            pullLow           = romBit;
            strobes.stepPhase = 1'b1;
          end else if (phase == 2'd2 && rxValid) begin
            if (rxBit != romBit) begin
              nextState = ST_DEAD;
            end else begin
              strobes.stepIdx  = 1'b1;
              strobes.clrPhase = 1'b1;
              if (lastRomBit) begin
                nextState = ST_DONE;
                setSel    = 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_DEAD;
      selected <= 1'b0;
      presence <= 1'b0;
    end else begin
      state    <= nextState;
      presence <= busReset;
      if (busReset)    selected <= 1'b0;
      else if (setSel) selected <= 1'b1;
    end
  end
endmodule

// File: rtl/owSlaveRom.sv
module owSlaveRom
  import owRomPkg::*;
#(
  parameter logic [7:0]  CLASS_CODE = 8'h2D,
  parameter logic [47:0] SERIAL_VAL = 48'h0000_5A3C_91E7
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReset,
  input  logic rxValid,
  input  logic rxBit,
  input  logic txReq,
  output logic pullLow,
  output logic presence,
  output logic selected
);
  romStrobes_t         strobes;
  logic [CMD_BITS-1:0] cmdNext;
  logic                lastCmdBit, lastRomBit, romBit;
  logic [1:0]          phase;

  owRomDatapath #(.CLASS_CODE(CLASS_CODE), .SERIAL_VAL(SERIAL_VAL)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxBit(rxBit),
    .cmdNext(cmdNext), .lastCmdBit(lastCmdBit), .lastRomBit(lastRomBit),
    .romBit(romBit), .phase(phase)
  );

  owRomControl ctl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid),
    .rxBit(rxBit), .txReq(txReq), .cmdNext(cmdNext), .lastCmdBit(lastCmdBit),
    .lastRomBit(lastRomBit), .romBit(romBit), .phase(phase),
    .strobes(strobes), .pullLow(pullLow), .presence(presence),
    .selected(selected)
  );
endmodule

// File: rtl/owSlaveRomChk.sv
module owSlaveRomChk (
  input logic clk,
  input logic rstN,
  input logic busReset,
  input logic txReq,
  input logic pullLow,
  input logic presence,
  input logic selected
);
  logic seenReset;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         seenReset <= 1'b0;
    else if (busReset) seenReset <= 1'b1;
  end

  AST_PRESENCE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> presence); // R1
  AST_PRESENCE_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    !busReset |=> !presence); // R1
  AST_NO_SEL_BEFORE_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !seenReset |-> !selected); // R1
  AST_DRIVE_ONLY_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    !txReq |-> !pullLow); // R11
  AST_RESET_DESELECTS: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !selected); // R13
  AST_SELECT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (selected && !busReset) |=> selected); // R10
endmodule

bind owSlaveRom owSlaveRomChk chk (
  .clk(clk), .rstN(rstN), .busReset(busReset), .txReq(txReq),
  .pullLow(pullLow), .presence(presence), .selected(selected)
);

// File: tb/owSlaveRom_test.sv
module owSlaveRom_test;
  localparam logic [7:0]  CLS = 8'h2D;
  localparam logic [47:0] SER = 48'h0000_5A3C_91E7;

  logic clk = 1'b0, rstN = 1'b0;
  logic busReset = 1'b0, rxValid = 1'b0, rxBit = 1'b0, txReq = 1'b0;
  logic pullLow, presence, selected;
  int checks = 0, fails = 0;
  logic [63:0] ident;

  always #5 clk = ~clk;

  owSlaveRom #(.CLASS_CODE(CLS), .SERIAL_VAL(SER)) uut (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid),
    .rxBit(rxBit), .txReq(txReq), .pullLow(pullLow), .presence(presence),
    .selected(selected)
  );

  function automatic logic [7:0] refCrc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 8'h8C;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseReset();
    @(negedge clk) busReset = 1'b1;
    @(negedge clk) busReset = 1'b0;
  endtask

  task automatic writeBit(input logic b);
    @(negedge clk) begin rxValid = 1'b1; rxBit = b; end
    @(negedge clk) rxValid = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] code);
    for (int i = 0; i < 8; i++) writeBit(code[i]);
  endtask

  task automatic readSlot(output logic low);
    @(negedge clk) txReq = 1'b1;
    #1 low = pullLow;
    @(negedge clk) txReq = 1'b0;
  endtask

  task automatic testResetState();
    check(!selected && !presence && !pullLow, "R1 reset state", selected, 0);
    sendCmd(8'hCC);
    check(!selected, "R1 bypass before first bus reset ignored", selected, 0);
    @(negedge clk) busReset = 1'b1;
    @(negedge clk) busReset = 1'b0;
    check(presence, "R1 presence after bus reset", presence, 1);
    @(negedge clk);
    check(!presence, "R1 presence one cycle", presence, 0);
  endtask

  task automatic testSkip();
    pulseReset();
    for (int i = 0; i < 7; i++) writeBit(8'hCC >> i);
    check(!selected, "R2 no select before 8th bit", selected, 0);
    writeBit(1'b1);
    check(selected, "R10 bypass selects", selected, 0 + 1);
    repeat (3) @(negedge clk);
    check(selected, "R10 selection holds", selected, 1);
    pulseReset();
    check(!selected, "R13 bus reset deselects", selected, 0);
  endtask

  task automatic testRead();
    int bad = 0;
    logic low;
    pulseReset();
    sendCmd(8'h33);
    for (int i = 0; i < 64; i++) begin
      readSlot(low);
      if (low !== !ident[i]) bad++;
      if (i == 62 && selected) bad += 100;
    end
    check(bad == 0, "R3 R11 readout bits", bad, 0);
    check(selected, "R4 select after readout", selected, 1);
  endtask

  task automatic testMatch();
    logic low;
    pulseReset();
    sendCmd(8'h55);
    for (int i = 0; i < 63; i++) writeBit(ident[i]);
    check(!selected, "R5 not selected before last bit", selected, 0);
    writeBit(ident[63]);
    check(selected, "R5 compare selects", selected, 1);
    pulseReset();
    sendCmd(8'h55);
    for (int i = 0; i < 10; i++) writeBit(ident[i]);
    writeBit(!ident[10]);
    for (int i = 11; i < 64; i++) writeBit(ident[i]);
    check(!selected, "R6 mismatch never selects", selected, 0);
    readSlot(low);
    check(!low, "R6 silent after mismatch", low, 0);
  endtask

  task automatic testSearch();
    int bad = 0;
    logic t, c, low;
    pulseReset();
    sendCmd(8'hF0);
    for (int i = 0; i < 64; i++) begin
      readSlot(t);
      readSlot(c);
      if (t !== !ident[i] || c !== ident[i]) bad++;
      writeBit(ident[i]);
      if (i == 62 && selected) bad += 100;
    end
    check(bad == 0, "R7 search triplets", bad, 0);
    check(selected, "R9 full search selects", selected, 1);
    pulseReset();
    sendCmd(8'hF0);
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      readSlot(t); readSlot(c); writeBit(ident[i]);
    end
    readSlot(t); readSlot(c);
    writeBit(!ident[5]);
    for (int i = 0; i < 20; i++) begin
      readSlot(low);
      if (low) bad++;
    end
    check(bad == 0, "R8 released after drop-out", bad, 0);
    check(!selected, "R8 dropped device unselected", selected, 0);
  endtask

  task automatic testBadCmd();
    int bad = 0;
    logic low;
    pulseReset();
    sendCmd(8'hA5);
    for (int i = 0; i < 16; i++) begin
      readSlot(low);
      if (low) bad++;
    end
    sendCmd(8'hCC);
    check(bad == 0, "R12 unknown code silent", bad, 0);
    check(!selected, "R12 unknown code no select", selected, 0);
  endtask

  task automatic testAbort();
    int bad = 0;
    logic low;
    pulseReset();
    sendCmd(8'h33);
    for (int i = 0; i < 20; i++) readSlot(low);
    pulseReset();
    sendCmd(8'h33);
    for (int i = 0; i < 8; i++) begin
      readSlot(low);
      if (low !== !ident[i]) bad++;
    end
    check(bad == 0, "R13 readout restarts at bit 0", bad, 0);
    check(!selected, "R13 aborted op not selected", selected, 0);
  endtask

  initial begin
    ident = {refCrc({SER, CLS}), SER, CLS};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testSkip();
    testRead();
    testMatch();
    testSearch();
    testBadCmd();
    testAbort();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule